// File: doc/BRIEF.md
# Weighted Round Robin Queue Arbiter

This block decides which submission queue may hand its next command to the command fetch engine of a storage controller. Queue 0 is the admin queue, and queues 1 to N_IO are I/O queues. Each I/O queue is assigned to one of four service classes through a small write port. The admin queue always comes first. The urgent class comes next. The high, medium and low classes then share the remaining grants by weighted round robin, using a programmable 8-bit weight per class. Inside any class, the requesting queues take turns in round robin order.

A grant is offered in the same cycle as the request, but only while the fetch engine holds `accept` high. The arbiter's pointers and credit counters advance only on a grant that is actually issued. A mode input replaces the whole tiered scheme with one plain round robin over every queue, the admin queue included.

Top module: `wrr_queue_arbiter`

## Requirements
- R1: With `rr_mode` low, a request from queue 0 (admin) wins over every I/O queue whenever `accept` is high.
- R2: With `rr_mode` low and queue 0 idle, any requesting queue of class code 0 (urgent) wins over queues of class codes 1 (high), 2 (medium) and 3 (low).
- R3: Between classes 1, 2 and 3, a class whose weight is w receives up to w+1 consecutive grants while it keeps requesting. The weighted stage then moves on in the cyclic order high, medium, low, high.
- R4: When the weighted stage reaches a class with no requesting queue, it skips that class at once, and that class's remaining credit is discarded for the current round.
- R5: All three credit counters are refilled to weight+1 as soon as no requesting class has credit left. The first weighted grant after reset works from refilled credit.
- R6: Inside a class, the next grant goes to the first requesting queue of that class with an index above the queue that class last granted, wrapping around. After reset each class starts its search at queue 1.
- R7: With `rr_mode` high, classes and weights are ignored. Queues 0 to N_IO are served in plain round robin after the last queue granted in this mode, and the search starts at queue 0 after reset.
- R8: While `accept` is low, `gnt_valid` is low, `gnt` is zero, and no pointer or credit changes.
- R9: With no request present, `gnt_valid` is low and the arbiter state is unchanged.
- R10: When `gnt_valid` is high, `gnt` has exactly one bit set, that bit is `gnt_idx`, and the queue is requesting.
- R11: A class write with `cfg_cls_we` takes effect from the next cycle. Writes that name queue 0 or an index above N_IO are ignored. A weight write selects high, medium or low with `cfg_wt_sel` values 0, 1 or 2, and the value 3 is ignored. After reset every I/O queue is in class 3 and every weight is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 1: plain round robin over all queues |
| accept | input | 1 | Fetch engine can take a grant this cycle |
| req | input | N_IO+1 | Request per queue, bit 0 is the admin queue |
| cfg_cls_we | input | 1 | Class write strobe |
| cfg_cls_qid | input | clog2(N_IO+1) | Queue whose class is written |
| cfg_cls_val | input | 2 | Class code: 0 urgent, 1 high, 2 medium, 3 low |
| cfg_wt_we | input | 1 | Weight write strobe |
| cfg_wt_sel | input | 2 | Weight target: 0 high, 1 medium, 2 low |
| cfg_wt_val | input | WW | Weight value |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt | output | N_IO+1 | One-hot grant |
| gnt_idx | output | clog2(N_IO+1) | Index of the granted queue |

## Verification
The bench builds the block with its defaults: eight I/O queues, which gives a 4-bit queue index, and 8-bit weights. It places two queues in each class, so every inner round robin has to wrap. It uses weights of 0 to 3, so credit runs out and refills many times within a short run. Because the 4-bit index can name queues 9 to 15, the random class writes also reach the ignored indices above the last queue, as well as queue 0. Random phases switch `rr_mode` and drop `accept`, so pointer state carried across mode changes and stalled cycles is compared on every clock.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
    typedef enum logic [1:0] {
        CLS_URGENT = 2'd0,
        CLS_HIGH   = 2'd1,
        CLS_MEDIUM = 2'd2,
        CLS_LOW    = 2'd3
    } qclass_e;

    localparam int NUM_CLS  = 4;   // urgent plus three weighted classes
    localparam int NUM_WCLS = 3;   // classes sharing the weighted tier
endpackage

// File: rtl/wrr_cfg_regs.sv
module wrr_cfg_regs
    import wrr_arb_pkg::*;
#(
    parameter int N_Q = 9,
    parameter int IW  = 4,
    parameter int WW  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cls_we,
    input  logic [IW-1:0]                 cls_qid,
    input  logic [1:0]                    cls_val,
    input  logic                          wt_we,
    input  logic [1:0]                    wt_sel,
    input  logic [WW-1:0]                 wt_val,
    output logic [N_Q-1:0][1:0]           cls_o,
    output logic [NUM_WCLS-1:0][WW-1:0]   wt_o
);
    logic [N_Q-1:0][1:0]         cls_d, cls_q;
    logic [NUM_WCLS-1:0][WW-1:0] wt_d, wt_q;

    always_comb begin
        cls_d = cls_q;
        wt_d  = wt_q;
        // queue 0 keeps its fixed role; out-of-range indices fall through
        if (cls_we && (cls_qid != '0) && (int'(cls_qid) < N_Q)) begin
            cls_d[cls_qid] = cls_val;
        end
        if (wt_we && (int'(wt_sel) < NUM_WCLS)) begin
            wt_d[wt_sel] = wt_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < N_Q; q++) cls_q[q] <= CLS_LOW;
            wt_q <= '0;
        end else begin
            cls_q <= cls_d;
            wt_q  <= wt_d;
        end
    end

    assign cls_o = cls_q;
    assign wt_o  = wt_q;
endmodule

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    int j;

    // scan from the farthest offset down so the nearest match is kept
    always_comb begin
        found = 1'b0;
        idx   = '0;
        j     = 0;
        for (int k = N; k >= 1; k--) begin
            j = int'(last) + k;
            if (j >= N) j = j - N;
            if (j < N && mask[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/wrr_weight_stage.sv
module wrr_weight_stage
    import wrr_arb_pkg::*;
#(
    parameter int WW = 8,
    parameter int CW = WW + 1
) (
    input  logic [NUM_WCLS-1:0]           has,
    input  logic [NUM_WCLS-1:0][CW-1:0]   cred_q,
    input  logic [NUM_WCLS-1:0][WW-1:0]   wt,
    input  logic [1:0]                    ptr_q,
    output logic                          found,
    output logic [1:0]                    win,
    output logic [NUM_WCLS-1:0][CW-1:0]   cred_d,
    output logic [1:0]                    ptr_d
);
    logic [NUM_WCLS-1:0]         live;
    logic                        reload;
    logic [NUM_WCLS-1:0][CW-1:0] eff;
    int                          c;
    int                          off;

    always_comb begin
        for (int i = 0; i < NUM_WCLS; i++) live[i] = has[i] && (cred_q[i] != '0);
        reload = (has != '0) && (live == '0);
        for (int i = 0; i < NUM_WCLS; i++) begin
            eff[i] = reload ? (CW'(wt[i]) + CW'(1)) : cred_q[i];
        end

        found = 1'b0;
        win   = '0;
        off   = 0;
        c     = 0;
        for (int k = NUM_WCLS - 1; k >= 0; k--) begin
            c = int'(ptr_q) + k;
            if (c >= NUM_WCLS) c = c - NUM_WCLS;
            if (has[c] && (eff[c] != '0)) begin
                found = 1'b1;
                win   = 2'(c);
                off   = k;
            end
        end

        cred_d = eff;
        for (int k = 0; k < NUM_WCLS; k++) begin
            c = int'(ptr_q) + k;
            if (c >= NUM_WCLS) c = c - NUM_WCLS;
            if (k < off)       cred_d[c] = '0;
            else if (k == off) cred_d[c] = eff[c] - CW'(1);
        end

        if (eff[win] == CW'(1)) ptr_d = (win == 2'd2) ? 2'd0 : win + 2'd1;
        else                    ptr_d = win;
    end
endmodule

// File: rtl/wrr_queue_arbiter.sv
module wrr_queue_arbiter
    import wrr_arb_pkg::*;
#(
    parameter  int N_IO = 8,
    parameter  int WW   = 8,
    localparam int N_Q  = N_IO + 1,
    localparam int IW   = $clog2(N_Q)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rr_mode,
    input  logic           accept,
    input  logic [N_Q-1:0] req,
    input  logic           cfg_cls_we,
    input  logic [IW-1:0]  cfg_cls_qid,
    input  logic [1:0]     cfg_cls_val,
    input  logic           cfg_wt_we,
    input  logic [1:0]     cfg_wt_sel,
    input  logic [WW-1:0]  cfg_wt_val,
    output logic           gnt_valid,
    output logic [N_Q-1:0] gnt,
    output logic [IW-1:0]  gnt_idx
);
    localparam int CW = WW + 1;

    typedef struct packed {
        logic [NUM_CLS-1:0][IW-1:0]  last;
        logic [IW-1:0]               last_all;
        logic [NUM_WCLS-1:0][CW-1:0] cred;
        logic [1:0]                  wptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [N_Q-1:0][1:0]         cls;
    logic [NUM_WCLS-1:0][WW-1:0] wt;

    wrr_cfg_regs #(.N_Q(N_Q), .IW(IW), .WW(WW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls_we  (cfg_cls_we),
        .cls_qid (cfg_cls_qid),
        .cls_val (cfg_cls_val),
        .wt_we   (cfg_wt_we),
        .wt_sel  (cfg_wt_sel),
        .wt_val  (cfg_wt_val),
        .cls_o   (cls),
        .wt_o    (wt)
    );

    logic [NUM_CLS-1:0][N_Q-1:0] cmask;

    always_comb begin
        cmask = '0;
        for (int q = 1; q < N_Q; q++) cmask[cls[q]][q] = req[q];
    end

    logic [NUM_CLS-1:0]          cfound;
    logic [NUM_CLS-1:0][IW-1:0]  cidx;

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls_rr
        wrr_rr_pick #(.N(N_Q), .IW(IW)) u_pick (
            .mask  (cmask[g]),
            .last  (st_q.last[g]),
            .found (cfound[g]),
            .idx   (cidx[g])
        );
    end

    logic          all_found;
    logic [IW-1:0] all_idx;

    wrr_rr_pick #(.N(N_Q), .IW(IW)) u_pick_all (
        .mask  (req),
        .last  (st_q.last_all),
        .found (all_found),
        .idx   (all_idx)
    );

    logic [NUM_WCLS-1:0]         has;
    logic                        ws_found;
    logic [1:0]                  ws_win;
    logic [NUM_WCLS-1:0][CW-1:0] ws_cred;
    logic [1:0]                  ws_ptr;

    assign has = {cfound[3], cfound[2], cfound[1]};

    wrr_weight_stage #(.WW(WW), .CW(CW)) u_wstage (
        .has    (has),
        .cred_q (st_q.cred),
        .wt     (wt),
        .ptr_q  (st_q.wptr),
        .found  (ws_found),
        .win    (ws_win),
        .cred_d (ws_cred),
        .ptr_d  (ws_ptr)
    );

    logic          pick_v;
    logic [IW-1:0] pick_idx;
    logic [1:0]    wsel;

    always_comb begin
        st_d     = st_q;
        pick_v   = 1'b0;
        pick_idx = '0;
        wsel     = ws_win + 2'd1;
        if (rr_mode) begin
            pick_v   = all_found;
            pick_idx = all_idx;
            if (accept && pick_v) st_d.last_all = all_idx;
        end else if (req[0]) begin
            pick_v   = 1'b1;
            pick_idx = '0;
        end else if (cfound[CLS_URGENT]) begin
            pick_v   = 1'b1;
            pick_idx = cidx[CLS_URGENT];
            if (accept) st_d.last[CLS_URGENT] = pick_idx;
        end else if (ws_found) begin
            pick_v   = 1'b1;
            pick_idx = cidx[wsel];
            if (accept) begin
                st_d.last[wsel] = pick_idx;
                st_d.cred       = ws_cred;
                st_d.wptr       = ws_ptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.last     <= '0;
            st_q.last_all <= IW'(N_Q - 1);
            st_q.cred     <= '0;
            st_q.wptr     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_valid = pick_v && accept;
    assign gnt       = gnt_valid ? (N_Q'(1) << pick_idx) : '0;
    assign gnt_idx   = pick_idx;
endmodule

// File: rtl/wrr_arb_checker.sv
module wrr_arb_checker #(
    parameter int N_Q = 9,
    parameter int IW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rr_mode,
    input logic           accept,
    input logic [N_Q-1:0] req,
    input logic           gnt_valid,
    input logic [N_Q-1:0] gnt,
    input logic [IW-1:0]  gnt_idx
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(gnt) == 1 && gnt[gnt_idx]));

    p_granted_requests_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (!gnt_valid && gnt == '0));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !gnt_valid);

    p_admin_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_mode && accept && req[0]) |-> gnt[0]);

    // plain mode: a queue granted last cycle yields to another that still requests
    p_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rr_mode && gnt_valid && $past(rr_mode && gnt_valid)
         && $countones(req & $past(req)) >= 2 && req[$past(gnt_idx)])
        |-> (gnt_idx != $past(gnt_idx)));
endmodule

bind wrr_queue_arbiter wrr_arb_checker #(.N_Q(N_Q), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rr_mode   (rr_mode),
    .accept    (accept),
    .req       (req),
    .gnt_valid (gnt_valid),
    .gnt       (gnt),
    .gnt_idx   (gnt_idx)
);

// File: tb/wrr_queue_arbiter_test.sv
`timescale 1ns/1ps
module wrr_queue_arbiter_test;
    localparam int N_IO = 8;
    localparam int N_Q  = N_IO + 1;
    localparam int IW   = $clog2(N_Q);
    localparam int WW   = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rr_mode = 1'b0;
    logic           accept = 1'b0;
    logic [N_Q-1:0] req = '0;
    logic           cfg_cls_we = 1'b0;
    logic [IW-1:0]  cfg_cls_qid = '0;
    logic [1:0]     cfg_cls_val = '0;
    logic           cfg_wt_we = 1'b0;
    logic [1:0]     cfg_wt_sel = '0;
    logic [WW-1:0]  cfg_wt_val = '0;
    logic           gnt_valid;
    logic [N_Q-1:0] gnt;
    logic [IW-1:0]  gnt_idx;

    always #4 clk = ~clk;

    wrr_queue_arbiter #(.N_IO(N_IO), .WW(WW)) uut (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .accept(accept), .req(req),
        .cfg_cls_we(cfg_cls_we), .cfg_cls_qid(cfg_cls_qid), .cfg_cls_val(cfg_cls_val),
        .cfg_wt_we(cfg_wt_we), .cfg_wt_sel(cfg_wt_sel), .cfg_wt_val(cfg_wt_val),
        .gnt_valid(gnt_valid), .gnt(gnt), .gnt_idx(gnt_idx)
    );

    // behavioural reference state
    int m_cls[N_Q];
    int m_wt[3];
    int m_cred[3];
    int m_wptr;
    int m_last[4];
    int m_lall;
    // outcome of the current cycle
    bit m_v;
    int m_idx;
    int m_kind;  // 0 admin, 1 plain, 2 urgent, 3 weighted
    int m_wc;
    int n_cred[3];
    int n_wptr;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    function automatic int rr_next(bit [N_Q-1:0] m, int last);
        for (int k = 1; k <= N_Q; k++) begin
            if (m[(last + k) % N_Q]) return (last + k) % N_Q;
        end
        return -1;
    endfunction

    task automatic m_eval();
        bit [N_Q-1:0] cm[4];
        bit has[3];
        int eff[3];
        bit anylive, anyhas, pick;
        int off;
        pick = 0; m_idx = 0; m_kind = 0; m_wc = 0; off = 0;
        for (int c = 0; c < 4; c++) cm[c] = '0;
        for (int q = 1; q < N_Q; q++) cm[m_cls[q]][q] = req[q];
        if (rr_mode) begin
            if (req != '0) begin pick = 1; m_idx = rr_next(req, m_lall); m_kind = 1; end
        end else if (req[0]) begin
            pick = 1; m_idx = 0; m_kind = 0;
        end else if (cm[0] != '0) begin
            pick = 1; m_idx = rr_next(cm[0], m_last[0]); m_kind = 2;
        end else begin
            anylive = 0; anyhas = 0;
            for (int c = 0; c < 3; c++) begin
                has[c] = (cm[c+1] != '0);
                anyhas |= has[c];
                if (has[c] && m_cred[c] > 0) anylive = 1;
            end
            for (int c = 0; c < 3; c++) eff[c] = (anyhas && !anylive) ? m_wt[c] + 1 : m_cred[c];
            for (int k = 0; k < 3 && !pick; k++) begin
                int c = (m_wptr + k) % 3;
                if (has[c] && eff[c] > 0) begin pick = 1; m_wc = c; off = k; end
            end
            if (pick) begin
                m_kind = 3;
                m_idx  = rr_next(cm[m_wc+1], m_last[m_wc+1]);
                for (int k = 0; k < 3; k++) begin
                    int c = (m_wptr + k) % 3;
                    n_cred[c] = (k < off) ? 0 : (k == off) ? eff[c] - 1 : eff[c];
                end
                n_wptr = (n_cred[m_wc] == 0) ? (m_wc + 1) % 3 : m_wc;
            end
        end
        m_v = pick && accept;
    endtask

    task automatic m_commit();
        if (m_v) begin
            case (m_kind)
                1: m_lall = m_idx;
                2: m_last[0] = m_idx;
                3: begin
                    m_last[m_wc+1] = m_idx;
                    for (int c = 0; c < 3; c++) m_cred[c] = n_cred[c];
                    m_wptr = n_wptr;
                end
                default: ;
            endcase
        end
        if (cfg_cls_we && cfg_cls_qid != 0 && int'(cfg_cls_qid) < N_Q) m_cls[cfg_cls_qid] = cfg_cls_val;
        if (cfg_wt_we && cfg_wt_sel < 3) m_wt[cfg_wt_sel] = cfg_wt_val;
    endtask

    task automatic step(input string tag);
        logic [N_Q-1:0] exp_g;
        #2;
        m_eval();
        exp_g = m_v ? (N_Q'(1) << m_idx) : '0;
        n_cmp++;
        if (gnt_valid !== m_v || gnt !== exp_g || (m_v && gnt_idx !== IW'(m_idx))) begin
            n_bad++;
            $display("FAIL %s: valid=%0b gnt=%b idx=%0d expected valid=%0b gnt=%b idx=%0d",
                     tag, gnt_valid, gnt, gnt_idx, m_v, exp_g, m_idx);
        end
        @(posedge clk);
        m_commit();
        #1;
    endtask

    task automatic set_cls(input int q, input int v, input string tag);
        cfg_cls_we = 1; cfg_cls_qid = IW'(q); cfg_cls_val = 2'(v);
        step(tag);
        cfg_cls_we = 0;
    endtask

    task automatic set_wt(input int s, input int v, input string tag);
        cfg_wt_we = 1; cfg_wt_sel = 2'(s); cfg_wt_val = WW'(v);
        step(tag);
        cfg_wt_we = 0;
    endtask

    initial begin
        for (int q = 0; q < N_Q; q++) m_cls[q] = 3;
        for (int c = 0; c < 3; c++) begin m_wt[c] = 0; m_cred[c] = 0; end
        for (int c = 0; c < 4; c++) m_last[c] = 0;
        m_wptr = 0; m_lall = N_Q - 1;

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        accept = 1;
        step("R9");                     // reset state, nothing requested
        step("R9");
        // R11: reset class is low for every I/O queue
        req = 9'b000100010;
        repeat (3) step("R11");
        req = '0;
        // R11: writes to queue 0, to an index past the last queue, and to weight select 3
        set_cls(0, 0, "R11");
        set_cls(12, 0, "R11");
        set_wt(3, 7, "R11");
        // two queues per class: 1,2 urgent; 3,4 high; 5,6 medium; 7,8 low
        set_cls(1, 0, "R11"); set_cls(2, 0, "R11");
        set_cls(3, 1, "R11"); set_cls(4, 1, "R11");
        set_cls(5, 2, "R11"); set_cls(6, 2, "R11");
        set_cls(7, 3, "R11"); set_cls(8, 3, "R11");
        set_wt(0, 2, "R11"); set_wt(1, 1, "R11"); set_wt(2, 0, "R11");

        req = '1;
        repeat (3) step("R1");
        req = 9'b111111110;
        repeat (4) step("R2");
        req = 9'b000000110;
        repeat (3) step("R6");
        req = 9'b111111000;
        repeat (14) step("R3");
        req = 9'b110011000;             // medium class drops out
        repeat (8) step("R4");
        req = 9'b110000000;             // only low class, weight 0
        repeat (4) step("R5");
        req = 9'b111111000;
        accept = 0;
        repeat (3) step("R8");
        accept = 1;
        repeat (4) step("R8");
        req = '0;
        repeat (2) step("R9");
        req = 9'b111111000;
        repeat (3) step("R9");
        rr_mode = 1;
        req = '1;
        repeat (10) step("R7");
        req = 9'b100000101;
        repeat (5) step("R7");
        rr_mode = 0;

        for (int n = 0; n < 3000; n++) begin
            if (n % 250 == 0) rr_mode = ($urandom % 3 == 0);
            req    = N_Q'($urandom) & N_Q'($urandom | (n % 7 == 0 ? 0 : 32'h1fe));
            accept = ($urandom % 8 != 0);
            if ($urandom % 20 == 0) begin
                cfg_cls_we = 1; cfg_cls_qid = IW'($urandom); cfg_cls_val = 2'($urandom);
            end
            if ($urandom % 30 == 0) begin
                cfg_wt_we = 1; cfg_wt_sel = 2'($urandom); cfg_wt_val = WW'($urandom % 4);
            end
            step("R10");
            cfg_cls_we = 0; cfg_wt_we = 0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule